// File: doc/BRIEF.md
# Burst Preamble Serializer

This block emits the one-bit-per-cycle preamble that goes in front of an encrypted burst and then passes the payload through. A single start pulse captures the burst settings. The block then sends a programmable run of alternating phasing bits, then a fixed 334-bit frame-sync pattern from a 21-stage shift-register generator, then a 128-bit initialization vector three times over. After that it hands the serial output to an upstream payload stream until that stream marks its last bit.

The output has no backpressure: in every preamble phase one bit leaves per clock with valid high. In the payload phase the block is transparent. It shows payload valid and payload bit on the output in the same cycle, and it asserts ready to the payload source. A phase code travels with the stream so that a downstream modem can tell the parts of the burst apart.

Top module: `burst_preamble_gen`

## Requirements
- R1: After reset, and while no burst is running, phase_o is 0 (done), ser_valid_o is 0 and pay_ready_o is 0.
- R2: A start pulse seen while phase_o is 0 makes phase_o 1 (phasing) on the next cycle for exactly idle_len_i cycles, and bit k of that run is idle_pol_i XOR (k mod 2). An idle_len_i of 0 goes straight to phase 2.
- R3: Phase 2 (sync) lasts exactly 334 cycles. Sync bit i is bit 20 of the generator state after i steps, and one step maps state s to {s[19:0], s[20] XOR s[9]} (polynomial x^21+x^10+1). The state starts at the seed, so the first sync bit is seed bit 20.
- R4: A seed of zero is loaded as the value 1, so the generator never sits in the all-zero state.
- R5: Phase 3 (vector) lasts 384 cycles, and bit j is iv_i[127 - (j mod 128)]. The vector therefore goes out three times, most significant bit first.
- R6: On the cycle after the last vector bit, phase_o is 4 (payload). In that phase pay_ready_o is 1, ser_valid_o equals pay_valid_i and ser_bit_o equals pay_bit_i in the same cycle.
- R7: A payload beat with pay_valid_i and pay_last_i both high returns phase_o to 0 on the next cycle.
- R8: start_i has no effect unless phase_o is 0. Seed, vector, idle length and polarity are captured at the accepted start, and later changes to those inputs do not alter the burst.
- R9: ser_valid_o is 1 on every cycle of phases 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst (accepted only when done) |
| idle_len_i | input | IDLE_W | Number of phasing bits |
| idle_pol_i | input | 1 | First phasing bit value |
| seed_i | input | 21 | Sync generator seed |
| iv_i | input | IV_W | Initialization vector |
| pay_bit_i | input | 1 | Payload bit |
| pay_valid_i | input | 1 | Payload bit valid |
| pay_last_i | input | 1 | Final payload bit of the burst |
| pay_ready_o | output | 1 | Payload accepted this cycle |
| ser_bit_o | output | 1 | Serial output bit |
| ser_valid_o | output | 1 | Serial output valid |
| phase_o | output | 3 | 0 done, 1 phasing, 2 sync, 3 vector, 4 payload |

## Verification
The bench counts every phase boundary to the exact cycle. A design with an off-by-one in the sync length or in the vector repeat count would shift every later bit, and the comparison against the expected stream would fail. A zero idle length catches a design that sends a stray phasing bit. A zero seed catches a generator that locks up at zero. A start pulse given during the burst, together with a changed vector, seed and polarity, catches a design that restarts or that reads its inputs live instead of the captured copies. Payload beats with gaps check that valid is passed through rather than held high, and that only a valid last beat ends the burst.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    localparam int LFSR_W   = 21;
    localparam int LFSR_TAP = 10;

    typedef enum logic [2:0] {
        PH_DONE = 3'd0,
        PH_IDLE = 3'd1,
        PH_SYNC = 3'd2,
        PH_IV   = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    typedef struct packed {
        logic load;
        logic step;
    } shift_ctl_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP-1]};
    endfunction
endpackage

// File: rtl/bpg_sync_lfsr.sv
module bpg_sync_lfsr
    import bpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic              bit_o
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= {{(LFSR_W-1){1'b0}}, 1'b1};
        else if (ctl_i.load)
            state_q <= (seed_i == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : seed_i;
        else if (ctl_i.step)
            state_q <= lfsr_next(state_q);
    end

    assign bit_o = state_q[LFSR_W-1];

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_i.step |-> state_q != '0);
endmodule

// File: rtl/bpg_iv_shifter.sv
module bpg_iv_shifter
    import bpg_pkg::*;
#(
    parameter int IV_W = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  shift_ctl_t      ctl_i,
    input  logic [IV_W-1:0] iv_i,
    output logic            bit_o
);
    logic [IV_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (ctl_i.load)
            sh_q <= iv_i;
        else if (ctl_i.step)
            sh_q <= {sh_q[IV_W-2:0], sh_q[IV_W-1]};
    end

    assign bit_o = sh_q[IV_W-1];

    p_iv_msb_first_r5: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> bit_o == $past(iv_i[IV_W-1]));
endmodule

// File: rtl/bpg_phase_ctrl.sv
module bpg_phase_ctrl
    import bpg_pkg::*;
#(
    parameter int IDLE_W   = 16,
    parameter int SYNC_LEN = 334,
    parameter int IV_W     = 128,
    parameter int IV_REPS  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IDLE_W-1:0] idle_len_i,
    input  logic              idle_pol_i,
    input  logic              pay_valid_i,
    input  logic              pay_last_i,
    output phase_e            phase_o,
    output logic              idle_bit_o,
    output shift_ctl_t        lfsr_ctl_o,
    output shift_ctl_t        iv_ctl_o
);
    localparam int SYNC_CW = $clog2(SYNC_LEN);
    localparam int IV_CW   = $clog2(IV_W);
    localparam int MID_W   = (SYNC_CW > IV_CW) ? SYNC_CW : IV_CW;
    localparam int CNT_W   = (IDLE_W > MID_W) ? IDLE_W : MID_W;
    localparam int REP_W   = $clog2(IV_REPS + 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [REP_W-1:0]  rep_q;
    logic [IDLE_W-1:0] idle_len_q;
    logic              idle_pol_q;
    logic              accept;
    logic              idle_last, sync_last, iv_last, rep_last;

    assign accept    = (phase_q == PH_DONE) && start_i;
    assign idle_last = cnt_q == (CNT_W'(idle_len_q) - CNT_W'(1));
    assign sync_last = cnt_q == CNT_W'(SYNC_LEN - 1);
    assign iv_last   = cnt_q == CNT_W'(IV_W - 1);
    assign rep_last  = rep_q == REP_W'(IV_REPS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_DONE;
            cnt_q      <= '0;
            rep_q      <= '0;
            idle_len_q <= '0;
            idle_pol_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_DONE: if (start_i) begin
                    idle_len_q <= idle_len_i;
                    idle_pol_q <= idle_pol_i;
                    cnt_q      <= '0;
                    rep_q      <= '0;
                    phase_q    <= (idle_len_i == '0) ? PH_SYNC : PH_IDLE;
                end
                PH_IDLE: begin
                    cnt_q <= idle_last ? '0 : cnt_q + CNT_W'(1);
                    if (idle_last) phase_q <= PH_SYNC;
                end
                PH_SYNC: begin
                    cnt_q <= sync_last ? '0 : cnt_q + CNT_W'(1);
                    if (sync_last) phase_q <= PH_IV;
                end
                PH_IV: begin
                    cnt_q <= iv_last ? '0 : cnt_q + CNT_W'(1);
                    if (iv_last) begin
                        rep_q <= rep_q + REP_W'(1);
                        if (rep_last) phase_q <= PH_DATA;
                    end
                end
                PH_DATA: if (pay_valid_i && pay_last_i) phase_q <= PH_DONE;
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    assign phase_o         = phase_q;
    assign idle_bit_o      = idle_pol_q ^ cnt_q[0];
    assign lfsr_ctl_o.load = accept;
    assign lfsr_ctl_o.step = (phase_q == PH_SYNC);
    assign iv_ctl_o.load   = accept;
    assign iv_ctl_o.step   = (phase_q == PH_IV);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SYNC && start_i && !sync_last)
        |=> (phase_q == PH_SYNC && cnt_q == $past(cnt_q) + CNT_W'(1)));
    p_sync_len_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SYNC && sync_last) |=> (phase_q == PH_IV && cnt_q == '0));
    p_iv_reps_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IV && iv_last && rep_last) |=> phase_q == PH_DATA);
    p_last_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && pay_valid_i && pay_last_i) |=> phase_q == PH_DONE);
endmodule

// File: rtl/burst_preamble_gen.sv
module burst_preamble_gen
    import bpg_pkg::*;
#(
    parameter int IDLE_W   = 16,
    parameter int SYNC_LEN = 334,
    parameter int IV_W     = 128,
    parameter int IV_REPS  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IDLE_W-1:0] idle_len_i,
    input  logic              idle_pol_i,
    input  logic [20:0]       seed_i,
    input  logic [IV_W-1:0]   iv_i,
    input  logic              pay_bit_i,
    input  logic              pay_valid_i,
    input  logic              pay_last_i,
    output logic              pay_ready_o,
    output logic              ser_bit_o,
    output logic              ser_valid_o,
    output logic [2:0]        phase_o
);
    phase_e     phase;
    logic       idle_bit, sync_bit, iv_bit;
    shift_ctl_t lfsr_ctl, iv_ctl;

    bpg_phase_ctrl #(
        .IDLE_W(IDLE_W), .SYNC_LEN(SYNC_LEN), .IV_W(IV_W), .IV_REPS(IV_REPS)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i),
        .idle_len_i(idle_len_i), .idle_pol_i(idle_pol_i),
        .pay_valid_i(pay_valid_i), .pay_last_i(pay_last_i),
        .phase_o(phase), .idle_bit_o(idle_bit),
        .lfsr_ctl_o(lfsr_ctl), .iv_ctl_o(iv_ctl)
    );

    bpg_sync_lfsr u_lfsr (
        .clk(clk), .rst(rst), .ctl_i(lfsr_ctl), .seed_i(seed_i), .bit_o(sync_bit)
    );

    bpg_iv_shifter #(.IV_W(IV_W)) u_iv (
        .clk(clk), .rst(rst), .ctl_i(iv_ctl), .iv_i(iv_i), .bit_o(iv_bit)
    );

    always_comb begin
        ser_bit_o   = 1'b0;
        ser_valid_o = 1'b0;
        pay_ready_o = 1'b0;
        case (phase)
            PH_IDLE: begin ser_bit_o = idle_bit; ser_valid_o = 1'b1; end
            PH_SYNC: begin ser_bit_o = sync_bit; ser_valid_o = 1'b1; end
            PH_IV:   begin ser_bit_o = iv_bit;   ser_valid_o = 1'b1; end
            PH_DATA: begin
                ser_bit_o   = pay_bit_i;
                ser_valid_o = pay_valid_i;
                pay_ready_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign phase_o = phase;

    p_idle_alternates_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (phase != PH_IDLE || ser_bit_o != $past(ser_bit_o)));
endmodule

// File: tb/burst_preamble_gen_tb.sv
module burst_preamble_gen_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [15:0]  idle_len_i = '0;
    logic         idle_pol_i = 1'b0;
    logic [20:0]  seed_i = '0;
    logic [127:0] iv_i = '0;
    logic         pay_bit_i = 1'b0, pay_valid_i = 1'b0, pay_last_i = 1'b0;
    logic         pay_ready_o, ser_bit_o, ser_valid_o;
    logic [2:0]   phase_o;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_preamble_gen u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .idle_len_i(idle_len_i),
        .idle_pol_i(idle_pol_i), .seed_i(seed_i), .iv_i(iv_i),
        .pay_bit_i(pay_bit_i), .pay_valid_i(pay_valid_i), .pay_last_i(pay_last_i),
        .pay_ready_o(pay_ready_o), .ser_bit_o(ser_bit_o),
        .ser_valid_o(ser_valid_o), .phase_o(phase_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // check one preamble bit at the current negedge, then move to the next negedge
    task automatic step_chk(input int ph, input bit b, input string tag);
        chk(phase_o == 3'(ph), {tag, " phase"}, phase_o, ph);
        chk(ser_valid_o == 1'b1, "R9 valid in preamble", ser_valid_o, 1);
        chk(ser_bit_o == b, {tag, " bit"}, ser_bit_o, b);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_burst(input int n_idle, input bit pol, input logic [20:0] seed,
                             input logic [127:0] iv, input bit poke);
        logic [20:0] s;
        bit pv, pb;
        s = (seed == '0) ? 21'd1 : seed;
        @(negedge clk);
        start_i = 1'b1; idle_len_i = 16'(n_idle); idle_pol_i = pol;
        seed_i = seed; iv_i = iv;
        @(negedge clk);
        start_i = poke;
        if (poke) begin iv_i = ~iv; idle_pol_i = ~pol; seed_i = seed ^ 21'h155; idle_len_i = 16'd9; end
        for (int k = 0; k < n_idle; k++) step_chk(1, pol ^ k[0], "R2 phasing");
        for (int i = 0; i < 334; i++) begin
            step_chk(2, s[20], (seed == '0) ? "R4 zero seed sync" : "R3 sync");
            s = {s[19:0], s[20] ^ s[9]};
        end
        for (int j = 0; j < 384; j++) step_chk(3, iv[127 - (j % 128)], poke ? "R8 captured iv" : "R5 iv");
        for (int d = 0; d < 6; d++) begin
            pv = (d != 2); pb = d[0] ^ iv[d];
            pay_valid_i = pv; pay_bit_i = pb; pay_last_i = (d == 5) || (d == 2);
            start_i = poke && (d == 1);
            #1;
            chk(phase_o == 3'd4, "R6 payload phase", phase_o, 4);
            chk(pay_ready_o == 1'b1, "R6 ready", pay_ready_o, 1);
            chk(ser_valid_o == pv, "R6 valid passthrough", ser_valid_o, pv);
            if (pv) chk(ser_bit_o == pb, "R6 bit passthrough", ser_bit_o, pb);
            @(negedge clk);
        end
        pay_valid_i = 1'b0; pay_last_i = 1'b0; start_i = 1'b0;
        chk(phase_o == 3'd0, "R7 last ends burst", phase_o, 0);
        chk(ser_valid_o == 1'b0, "R7 quiet after burst", ser_valid_o, 0);
        chk(pay_ready_o == 1'b0, "R7 ready low after burst", pay_ready_o, 0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(phase_o == 3'd0, "R1 reset phase", phase_o, 0);
            chk(ser_valid_o == 1'b0, "R1 reset valid", ser_valid_o, 0);
            chk(pay_ready_o == 1'b0, "R1 reset ready", pay_ready_o, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        run_burst(5, 1'b0, 21'h1ABCDE, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0);
        run_burst(0, 1'b1, 21'h0, 128'hDEAD_BEEF_0000_FFFF_A5A5_5A5A_1234_8765, 1'b0);
        run_burst(4, 1'b1, 21'h0F0F1, 128'h8000_0000_0000_0000_0000_0000_0000_0001, 1'b1);
        run_burst(1, 1'b0, 21'h100000, 128'hCAFE_F00D_5555_AAAA_0F0F_F0F0_3C3C_C3C3, 1'b0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule